// File: doc/BRIEF.md
# Interrupt Latch and Keyed Soft-Reset Register Block

This block sits next to a serial peripheral core and gathers its event pulses into sticky status bits. Each status bit can be masked by its own enable bit. A single global enable then gates the combined result onto one interrupt line. Software clears pending bits by writing ones to them, so writing back the value it just read acknowledges exactly the events it has seen.

A keyed reset register sits in the same 32-bit register space. Writing the key value 0x0A to it sends a one-cycle reset pulse to the peripheral core and its FIFOs. The same write also clears the status and enable registers here. Writing any other value does not reset anything: it latches a key-error bit in the status register instead, and that bit can raise the interrupt like any other source.

Top module: `periph_irq_ctrl`

## Requirements
- R1: A high on event input `evt_i[k]` (k = 0..6) at a clock edge sets status bit k, whether or not the source is enabled. The status register reads at offset 0x20. Bit 7 is the key-error bit (see R7).
- R2: A register write to 0x20 clears every status bit whose write-data bit is 1. An event arriving in the same cycle as a clear of its bit wins, and the bit stays set.
- R3: The enable register at offset 0x28 holds one enable per status bit in bits 7:0. It reads back what was written, and its bits 31:8 read as zero.
- R4: The global enable is bit 31 of offset 0x1C. A write loads it from write-data bit 31, and a read returns it in bit 31 with all other bits zero.
- R5: `irq_o` is high exactly when the global enable is set and at least one status bit is set together with its enable bit.
- R6: Writing 0x0A to offset 0x40 drives `core_rst_o` high for exactly the one cycle after the write. At the write edge it clears the status and enable registers, and an event in that same cycle is dropped. The global enable is kept.
- R7: Writing any value other than 0x0A to offset 0x40 sets status bit 7 and produces no `core_rst_o` pulse.
- R8: Reads of offset 0x40 and of any unmapped offset return zero. Writes to unmapped offsets change no register.
- R9: Asserting `rst_n` low clears the status, enable and global enable registers and holds `core_rst_o` and `irq_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe, one cycle per write |
| reg_addr_i | input | 8 | Register byte offset for both reads and writes |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| evt_i | input | 7 | Event pulses from the peripheral core |
| core_rst_o | output | 1 | One-cycle reset pulse to the peripheral core |
| irq_o | output | 1 | Interrupt output |

## Verification
The bench builds the block with its default parameters: seven event sources, an 8-bit offset and 32-bit data. This gives eight status bits, with the key-error bit at the top of the status byte. These values allow the tests to drive every event line at once, to read the zero-filled upper bits of the status and enable registers, and to check that only bit 31 of the global-enable word is stored. The cycle collisions are tested directly at these widths: an event against a clear of the same bit, and an event against a keyed reset.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam logic [31:0] OFS_GIE   = 32'h1C;
  localparam logic [31:0] OFS_STS   = 32'h20;
  localparam logic [31:0] OFS_EN    = 32'h28;
  localparam logic [31:0] OFS_RST   = 32'h40;
  localparam logic [31:0] RESET_KEY = 32'h0000_000A;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_GIE,
    SEL_STS,
    SEL_EN,
    SEL_RST
  } reg_sel_e;
endpackage

// File: rtl/irqc_src_bank.sv
module irqc_src_bank #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] w1c_i,
  input  logic            en_wr_i,
  input  logic [NSRC-1:0] en_wdata_i,
  input  logic            flush_i,
  output logic [NSRC-1:0] sts_o,
  output logic [NSRC-1:0] en_o
);
  logic [NSRC-1:0] sts_d, sts_q;
  logic [NSRC-1:0] en_d, en_q;

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    always_comb begin
      if (flush_i) begin
        sts_d[k] = 1'b0;
      end else begin
        sts_d[k] = set_i[k] | (sts_q[k] & ~w1c_i[k]);
      end
    end

    always_comb begin
      if (flush_i) begin
        en_d[k] = 1'b0;
      end else if (en_wr_i) begin
        en_d[k] = en_wdata_i[k];
      end else begin
        en_d[k] = en_q[k];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sts_q[k] <= 1'b0;
        en_q[k]  <= 1'b0;
      end else begin
        sts_q[k] <= sts_d[k];
        en_q[k]  <= en_d[k];
      end
    end

    // R1 / R2: an event outside a flush always leaves the bit set
    assert_evt_latch_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i[k] && !flush_i) |=> sts_q[k]);

    // R2: a clear with no competing event empties the bit
    assert_w1c_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (w1c_i[k] && !set_i[k]) |=> !sts_q[k]);

    // R6: a flush empties status and enable
    assert_flush_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> (!sts_q[k] && !en_q[k]));
  end

  assign sts_o = sts_q;
  assign en_o  = en_q;
endmodule

// File: rtl/irqc_rst_key.sv
module irqc_rst_key #(
  parameter int          DATA_W = 32,
  parameter logic [31:0] KEY    = 32'h0A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              flush_o,
  output logic              err_o,
  output logic              pulse_o
);
  logic key_ok;
  logic pulse_d, pulse_q;

  assign key_ok  = hit_i && (wdata_i == DATA_W'(KEY));
  assign flush_o = key_ok;
  assign err_o   = hit_i && !key_ok;

  always_comb begin
    pulse_d = key_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= pulse_d;
    end
  end

  assign pulse_o = pulse_q;

  // R6: the key write produces the pulse in the next cycle
  assert_key_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_i && wdata_i == DATA_W'(KEY)) |=> pulse_o);

  // R6: the pulse lasts one cycle unless the key is written again
  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_o && !hit_i) |=> !pulse_o);

  // R7: a wrong value never yields a pulse
  assert_bad_key_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_i && wdata_i != DATA_W'(KEY)) |=> !pulse_o);
endmodule

// File: rtl/periph_irq_ctrl.sv
module periph_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_EVT = 7,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic               core_rst_o,
  output logic               irq_o
);
  localparam int NSRC    = NUM_EVT + 1;
  localparam int GIE_BIT = DATA_W - 1;

  reg_sel_e        sel;
  logic            gie_d, gie_q;
  logic            key_flush, key_err;
  logic [NSRC-1:0] set_vec, w1c_vec, sts, en;

  always_comb begin
    if (reg_addr_i == ADDR_W'(OFS_GIE)) begin
      sel = SEL_GIE;
    end else if (reg_addr_i == ADDR_W'(OFS_STS)) begin
      sel = SEL_STS;
    end else if (reg_addr_i == ADDR_W'(OFS_EN)) begin
      sel = SEL_EN;
    end else if (reg_addr_i == ADDR_W'(OFS_RST)) begin
      sel = SEL_RST;
    end else begin
      sel = SEL_NONE;
    end
  end

  always_comb begin
    if (reg_wr_i && sel == SEL_GIE) begin
      gie_d = reg_wdata_i[GIE_BIT];
    end else begin
      gie_d = gie_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q <= 1'b0;
    end else begin
      gie_q <= gie_d;
    end
  end

  assign w1c_vec = (reg_wr_i && sel == SEL_STS) ? reg_wdata_i[NSRC-1:0] : '0;
  assign set_vec = {key_err, evt_i};

  irqc_rst_key #(
    .DATA_W (DATA_W),
    .KEY    (RESET_KEY)
  ) u_rst_key (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit_i   (reg_wr_i && sel == SEL_RST),
    .wdata_i (reg_wdata_i),
    .flush_o (key_flush),
    .err_o   (key_err),
    .pulse_o (core_rst_o)
  );

  irqc_src_bank #(
    .NSRC (NSRC)
  ) u_src_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (set_vec),
    .w1c_i      (w1c_vec),
    .en_wr_i    (reg_wr_i && sel == SEL_EN),
    .en_wdata_i (reg_wdata_i[NSRC-1:0]),
    .flush_i    (key_flush),
    .sts_o      (sts),
    .en_o       (en)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (sel)
      SEL_GIE: reg_rdata_o[GIE_BIT]   = gie_q;
      SEL_STS: reg_rdata_o[NSRC-1:0]  = sts;
      SEL_EN:  reg_rdata_o[NSRC-1:0]  = en;
      default: reg_rdata_o = '0;
    endcase
  end

  assign irq_o = gie_q && |(sts & en);

  // R4: the global enable follows bit 31 of a write to its offset
  assert_gie_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_addr_i == ADDR_W'(OFS_GIE)) |=> (gie_q == $past(reg_wdata_i[GIE_BIT])));

  // R5: no interrupt while the global enable is clear
  assert_irq_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_q |-> !irq_o);

  // R3 / R8: unused upper bits of status and enable read zero
  assert_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr_i == ADDR_W'(OFS_STS) || reg_addr_i == ADDR_W'(OFS_EN))
      |-> (reg_rdata_o[DATA_W-1:NSRC] == '0));

  // R8: the reset register reads as zero
  assert_rst_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr_i == ADDR_W'(OFS_RST)) |-> (reg_rdata_o == '0));
endmodule

// File: tb/test_periph_irq_ctrl.sv
module test_periph_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr_i;
  logic [7:0]  reg_addr_i;
  logic [31:0] reg_wdata_i;
  logic [31:0] reg_rdata_o;
  logic [6:0]  evt_i;
  logic        core_rst_o;
  logic        irq_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  periph_irq_ctrl i_periph_irq_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .evt_i       (evt_i),
    .core_rst_o  (core_rst_o),
    .irq_o       (irq_o)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  waddr;
    logic [31:0] wdata;
    logic [6:0]  evt;
    logic [7:0]  raddr;
    logic [31:0] exp_rd;
    logic        exp_irq;
    logic        exp_rst;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'h00, 32'h0,         7'h04, 8'h20, 32'h04,        1'b0, 1'b0}, // R1 latch while disabled
    '{1'b1, 8'h28, 32'h04,        7'h00, 8'h28, 32'h04,        1'b0, 1'b0}, // R3
    '{1'b1, 8'h1C, 32'h8000_0000, 7'h00, 8'h1C, 32'h8000_0000, 1'b1, 1'b0}, // R4 R5
    '{1'b1, 8'h20, 32'h04,        7'h00, 8'h20, 32'h00,        1'b0, 1'b0}, // R2 clear
    '{1'b0, 8'h00, 32'h0,         7'h21, 8'h20, 32'h21,        1'b0, 1'b0}, // R1 R5 masked
    '{1'b1, 8'h28, 32'hFFFF_FFFF, 7'h00, 8'h28, 32'hFF,        1'b1, 1'b0}, // R3 upper zero
    '{1'b1, 8'h20, 32'h01,        7'h01, 8'h20, 32'h21,        1'b1, 1'b0}, // R2 event wins
    '{1'b1, 8'h20, 32'h20,        7'h00, 8'h20, 32'h01,        1'b1, 1'b0}, // R2 selective
    '{1'b1, 8'h1C, 32'h7FFF_FFFF, 7'h00, 8'h1C, 32'h00,        1'b0, 1'b0}, // R4 only bit31
    '{1'b1, 8'h1C, 32'h8000_0000, 7'h00, 8'h20, 32'h01,        1'b1, 1'b0}, // R5
    '{1'b1, 8'h40, 32'h05,        7'h00, 8'h20, 32'h81,        1'b1, 1'b0}, // R7 bad key
    '{1'b1, 8'h40, 32'h0A,        7'h00, 8'h20, 32'h00,        1'b0, 1'b1}, // R6 key
    '{1'b0, 8'h00, 32'h0,         7'h00, 8'h28, 32'h00,        1'b0, 1'b0}, // R6 one cycle, en cleared
    '{1'b0, 8'h00, 32'h0,         7'h00, 8'h1C, 32'h8000_0000, 1'b0, 1'b0}, // R6 gie kept
    '{1'b0, 8'h00, 32'h0,         7'h00, 8'h40, 32'h00,        1'b0, 1'b0}, // R8 reset reg reads 0
    '{1'b0, 8'h00, 32'h0,         7'h00, 8'h30, 32'h00,        1'b0, 1'b0}, // R8 unmapped
    '{1'b1, 8'h30, 32'hFFFF_FFFF, 7'h00, 8'h28, 32'h00,        1'b0, 1'b0}, // R8 write ignored
    '{1'b1, 8'h20, 32'hFF,        7'h7F, 8'h20, 32'h7F,        1'b0, 1'b0}, // R1 R2 all events
    '{1'b1, 8'h28, 32'h80,        7'h00, 8'h20, 32'h7F,        1'b0, 1'b0}, // R5 no overlap
    '{1'b1, 8'h40, 32'h0B,        7'h00, 8'h20, 32'hFF,        1'b1, 1'b0}, // R7 error raises irq
    '{1'b1, 8'h40, 32'h0A,        7'h02, 8'h20, 32'h00,        1'b0, 1'b1}  // R6 reset beats event
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    reg_addr_i = a;
    #1;
    check(req, reg_rdata_o, exp);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_wr_i = 1'b0; reg_wdata_i = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr_i = 1'b0; reg_addr_i = '0; reg_wdata_i = '0; evt_i = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    rd(8'h20, 32'h0, "R9 status");
    rd(8'h28, 32'h0, "R9 enable");
    rd(8'h1C, 32'h0, "R9 gie");
    check("R9 irq", {31'b0, irq_o}, 32'h0);
    check("R9 core_rst", {31'b0, core_rst_o}, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      reg_wr_i = VEC[i].wr; reg_addr_i = VEC[i].waddr;
      reg_wdata_i = VEC[i].wdata; evt_i = VEC[i].evt;
      @(negedge clk);
      reg_wr_i = 1'b0; evt_i = '0; reg_wdata_i = '0;
      reg_addr_i = VEC[i].raddr;
      #2;
      check($sformatf("vec%0d rdata R1-set", i), reg_rdata_o, VEC[i].exp_rd);
      check($sformatf("vec%0d irq R5", i), {31'b0, irq_o}, {31'b0, VEC[i].exp_irq});
      check($sformatf("vec%0d core_rst R6", i), {31'b0, core_rst_o}, {31'b0, VEC[i].exp_rst});
    end

    // R6: pulse falls after one cycle
    @(negedge clk);
    check("R6 pulse ends", {31'b0, core_rst_o}, 32'h0);

    // R9: asynchronous reset mid-cycle after building state
    wr(8'h28, 32'hFF);
    @(negedge clk); evt_i = 7'h10;
    @(negedge clk); evt_i = '0;
    #1;
    check("R5 before reset irq", {31'b0, irq_o}, 32'h1);
    #1 rst_n = 1'b0;
    #1;
    rd(8'h20, 32'h0, "R9 async status");
    rd(8'h28, 32'h0, "R9 async enable");
    rd(8'h1C, 32'h0, "R9 async gie");
    check("R9 async irq", {31'b0, irq_o}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule